// File: doc/BRIEF.md
# Z80 Coprocessor Address Remapper

This block is the glue between a Z80 processor on an add-on card and the 6502-family host bus it shares. Whenever the card holds the bus grant, the block classifies each Z80 bus cycle and steers it to exactly one target:

- host main RAM;
- a small card-private scratch RAM;
- a window onto one pinned page of host banked RAM;
- a 16 KB card RAM that the host also maps as one of its ROM pages;
- a two-byte card shadow RAM;
- the host's memory-mapped I/O page;
- the host's bank-select registers.

For each cycle it produces one select line, a translated address, a bank page number and gated read and write strobes.

Z80 port I/O is folded into the host's fixed I/O page at $9F00. Memory cycles to $0000/$0001 land in card shadow RAM, so the reset jump stored there is never overwritten by the host's bank-select registers. Those two registers are instead reached through the two highest I/O ports. The pinned bank page for the $A000 window lives in a register that the host loads while it owns the bus.

The block is purely combinational on the access path, apart from the pinned-bank register. It is intended to sit between the Z80 pins and the card's RAM chip selects and host-bus drivers.

Top module: `z80_remap_top`

## Requirements
- R1: A qualified memory cycle to $0002–$9EFF asserts only `sel_host_ram`, with `map_addr` equal to the Z80 address.
- R2: A qualified memory cycle to $9F00–$9FFF asserts only `sel_priv_ram` (never `sel_host_io`), with `map_addr` = {8'h00, address[7:0]}.
- R3: A qualified memory cycle to $A000–$BFFF asserts only `sel_bank_win`, with `map_addr` equal to the Z80 address and `bank_page` equal to the pinned bank register; `bank_page` is 0 whenever `sel_bank_win` is low.
- R4: A qualified memory cycle to $C000–$FFFF asserts only `sel_card_rom`, with `map_addr` = address − $C000.
- R5: A qualified I/O cycle to ports $00–$FD (port = address[7:0], upper byte ignored) asserts only `sel_host_io`, with `map_addr` = $9F00 + port.
- R6: A qualified memory cycle to $0000 or $0001 asserts only `sel_zp_shadow`, with `map_addr` = address[0]; `sel_host_ram` stays low.
- R7: A qualified I/O cycle to port $FE or $FF asserts only `sel_bank_reg`, with `map_addr` = $0000 or $0001 respectively.
- R8: The pinned bank register resets to 0 and loads `cfg_data` on a rising clock edge when `cfg_we` is 1 and `z_grant` is 0; a `cfg_we` while `z_grant` is 1 has no effect.
- R9: An I/O cycle is recognised only when IORQ is low, M1 is high and MREQ is high, so interrupt-acknowledge cycles (IORQ and M1 both low) assert no select.
- R10: While `z_grant` is 0, every select is 0, `map_addr` and `bank_page` are 0, and both output strobes are 1.
- R11: A cycle is qualified only when RD or WR is low, so a refresh cycle (MREQ low with RD and WR high) or an idle bus asserts no select; at most one select is ever 1.
- R12: While a select is active, `out_rd_n` and `out_wr_n` follow `z_rd_n` and `z_wr_n`; with no select both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pinned-bank register |
| rst_n | input | 1 | Synchronous active-low reset |
| z_addr | input | 16 | Z80 address bus |
| z_mreq_n | input | 1 | Z80 memory request, active low |
| z_iorq_n | input | 1 | Z80 I/O request, active low |
| z_rd_n | input | 1 | Z80 read strobe, active low |
| z_wr_n | input | 1 | Z80 write strobe, active low |
| z_m1_n | input | 1 | Z80 machine cycle one, active low |
| z_grant | input | 1 | 1 while the Z80 owns the host bus |
| cfg_we | input | 1 | Host write enable for the pinned bank register |
| cfg_data | input | 8 | Host data for the pinned bank register |
| sel_host_ram | output | 1 | Host main RAM select |
| sel_priv_ram | output | 1 | Card-private 256-byte RAM select |
| sel_bank_win | output | 1 | Host banked-RAM window select |
| sel_card_rom | output | 1 | Card 16 KB RAM (host ROM page) select |
| sel_zp_shadow | output | 1 | Card shadow RAM for $0000/$0001 select |
| sel_host_io | output | 1 | Host I/O page select |
| sel_bank_reg | output | 1 | Host bank-select register select |
| map_addr | output | 16 | Translated address for the selected target |
| bank_page | output | 8 | Bank page for the banked-RAM window |
| out_rd_n | output | 1 | Gated read strobe, active low |
| out_wr_n | output | 1 | Gated write strobe, active low |

## Verification
The assertions assume that the Z80 never drives MREQ and IORQ low together. They also assume that `cfg_we` is used only while the host owns the bus: when it is raised with the grant held, the register is expected simply to keep its value. The stimulus meets these assumptions by applying one cycle type at a time through a vector table, with MREQ and IORQ mutually exclusive. Register loads are issued only on falling edges, so the control inputs are stable at every rising edge. Interrupt-acknowledge and refresh encodings are applied deliberately, because the properties claim that no select rises for them.

// File: rtl/z80map_pkg.sv
// Package z80map_pkg
// Shared target encoding for the Z80 address remapper.
// Assumes a 16-bit Z80 address bus; values other than those listed never occur.
package z80map_pkg;

    typedef enum logic [2:0] {
        T_NONE      = 3'd0,
        T_HOST_RAM  = 3'd1,
        T_PRIV      = 3'd2,
        T_BANK_WIN  = 3'd3,
        T_CARD_ROM  = 3'd4,
        T_ZP_SHADOW = 3'd5,
        T_HOST_IO   = 3'd6,
        T_BANK_REG  = 3'd7
    } tgt_e;

    localparam int NUM_TGT = 7;

endpackage

// File: rtl/z80_cycle_qual.sv
// Module z80_cycle_qual
// Classifies the current Z80 bus state as a memory cycle, an I/O cycle or neither.
// Assumes: active-low Z80 strobes. A cycle needs RD or WR low, which excludes
// refresh. An I/O cycle needs M1 high, which excludes interrupt acknowledge.
module z80_cycle_qual (
    input  logic mreq_n,
    input  logic iorq_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic m1_n,
    output logic mem_cyc,
    output logic io_cyc
);
    logic strobe_on;

    // Purpose: flag a real data transfer and split it by request type.
    always_comb begin
        strobe_on = !rd_n || !wr_n;
        mem_cyc   = !mreq_n && iorq_n && strobe_on;
        io_cyc    = !iorq_n && mreq_n && m1_n && strobe_on;
    end
endmodule

// File: rtl/z80_region_dec.sv
// Module z80_region_dec
// Maps a qualified Z80 cycle to a target and a translated address.
// Assumes mem_cyc and io_cyc are never both 1 (guaranteed by z80_cycle_qual).
module z80_region_dec
    import z80map_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [7:0]  IO_PAGE   = 8'h9F,
    parameter int          CARD_BITS = 14,
    parameter int          WIN_BITS  = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_cyc,
    input  logic              io_cyc,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] xaddr
);
    localparam int CARD_TAG_W = ADDR_W - CARD_BITS;
    localparam int WIN_TAG_W  = ADDR_W - WIN_BITS;
    localparam logic [CARD_TAG_W-1:0] CARD_TAG = '1;
    localparam logic [WIN_TAG_W-1:0]  WIN_TAG  = WIN_TAG_W'(5);

    logic [7:0] port;

    // Purpose: pick a target and form the address it sees.
    always_comb begin
        port  = addr[7:0];
        tgt   = T_NONE;
        xaddr = '0;
        if (mem_cyc) begin
            if (addr[ADDR_W-1:1] == '0) begin
                tgt   = T_ZP_SHADOW;
                xaddr = ADDR_W'(addr[0]);
            end else if (addr[ADDR_W-1 -: CARD_TAG_W] == CARD_TAG) begin
                tgt   = T_CARD_ROM;
                xaddr = ADDR_W'(addr[CARD_BITS-1:0]);
            end else if (addr[ADDR_W-1 -: WIN_TAG_W] == WIN_TAG) begin
                tgt   = T_BANK_WIN;
                xaddr = addr;
            end else if (addr[ADDR_W-1 -: 8] == IO_PAGE) begin
                tgt   = T_PRIV;
                xaddr = ADDR_W'(port);
            end else begin
                tgt   = T_HOST_RAM;
                xaddr = addr;
            end
        end else if (io_cyc) begin
            if (port[7:1] == 7'h7F) begin
                tgt   = T_BANK_REG;
                xaddr = ADDR_W'(port[0]);
            end else begin
                tgt   = T_HOST_IO;
                xaddr = ADDR_W'({IO_PAGE, port});
            end
        end
    end
endmodule

// File: rtl/bank_pin_reg.sv
// Module bank_pin_reg
// Holds the host bank page pinned behind the Z80 banked-RAM window.
// Assumes only the host drives cfg_we; loads are accepted only while the
// Z80 does not hold the grant.
module bank_pin_reg #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              grant,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] q
);
    // Purpose: reset to page 0, load on a host write outside the grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we && !grant)
            q <= din;
    end
endmodule

// File: rtl/z80_remap_top.sv
// Module z80_remap_top
// Top of the Z80 address remapper: qualifies cycles, decodes regions,
// drives one-hot selects, the translated address, the bank page and gated strobes.
// Assumes the Z80 never asserts MREQ and IORQ together; all outputs idle without the grant.
module z80_remap_top
    import z80map_pkg::*;
#(
    parameter int         ADDR_W  = 16,
    parameter int         BANK_W  = 8,
    parameter logic [7:0] IO_PAGE = 8'h9F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] z_addr,
    input  logic              z_mreq_n,
    input  logic              z_iorq_n,
    input  logic              z_rd_n,
    input  logic              z_wr_n,
    input  logic              z_m1_n,
    input  logic              z_grant,
    input  logic              cfg_we,
    input  logic [BANK_W-1:0] cfg_data,
    output logic              sel_host_ram,
    output logic              sel_priv_ram,
    output logic              sel_bank_win,
    output logic              sel_card_rom,
    output logic              sel_zp_shadow,
    output logic              sel_host_io,
    output logic              sel_bank_reg,
    output logic [ADDR_W-1:0] map_addr,
    output logic [BANK_W-1:0] bank_page,
    output logic              out_rd_n,
    output logic              out_wr_n
);
    logic              mem_cyc;
    logic              io_cyc;
    tgt_e              tgt;
    logic [ADDR_W-1:0] xaddr;
    logic [BANK_W-1:0] pinned_bank;
    logic [NUM_TGT-1:0] sel_vec;
    logic              any_sel;

    z80_cycle_qual u_qual (
        .mreq_n  (z_mreq_n),
        .iorq_n  (z_iorq_n),
        .rd_n    (z_rd_n),
        .wr_n    (z_wr_n),
        .m1_n    (z_m1_n),
        .mem_cyc (mem_cyc),
        .io_cyc  (io_cyc)
    );

    z80_region_dec #(
        .ADDR_W  (ADDR_W),
        .IO_PAGE (IO_PAGE)
    ) u_dec (
        .addr    (z_addr),
        .mem_cyc (mem_cyc),
        .io_cyc  (io_cyc),
        .tgt     (tgt),
        .xaddr   (xaddr)
    );

    bank_pin_reg #(
        .BANK_W (BANK_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .grant (z_grant),
        .din   (cfg_data),
        .q     (pinned_bank)
    );

    // One select per target code, gated by the bus grant.
    for (genvar t = 1; t <= NUM_TGT; t++) begin : g_sel
        assign sel_vec[t-1] = z_grant && (tgt == tgt_e'(t));
    end

    // Purpose: fan the select vector out to named ports.
    always_comb begin
        sel_host_ram  = sel_vec[T_HOST_RAM  - 1];
        sel_priv_ram  = sel_vec[T_PRIV      - 1];
        sel_bank_win  = sel_vec[T_BANK_WIN  - 1];
        sel_card_rom  = sel_vec[T_CARD_ROM  - 1];
        sel_zp_shadow = sel_vec[T_ZP_SHADOW - 1];
        sel_host_io   = sel_vec[T_HOST_IO   - 1];
        sel_bank_reg  = sel_vec[T_BANK_REG  - 1];
        any_sel       = |sel_vec;
    end

    // Purpose: force address, page and strobes idle when nothing is selected.
    always_comb begin
        map_addr  = any_sel ? xaddr : '0;
        bank_page = sel_bank_win ? pinned_bank : '0;
        out_rd_n  = any_sel ? z_rd_n : 1'b1;
        out_wr_n  = any_sel ? z_wr_n : 1'b1;
    end
endmodule

// File: rtl/z80_remap_chk.sv
// Module z80_remap_chk
// Property checker for z80_remap_top, attached by the bind below.
// Assumes the Z80 never drives MREQ and IORQ low together.
module z80_remap_chk #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] z_addr,
    input logic              z_mreq_n,
    input logic              z_iorq_n,
    input logic              z_rd_n,
    input logic              z_wr_n,
    input logic              z_m1_n,
    input logic              z_grant,
    input logic              sel_host_ram,
    input logic              sel_priv_ram,
    input logic              sel_bank_win,
    input logic              sel_card_rom,
    input logic              sel_zp_shadow,
    input logic              sel_host_io,
    input logic              sel_bank_reg,
    input logic [ADDR_W-1:0] map_addr,
    input logic [BANK_W-1:0] bank_page,
    input logic              out_rd_n,
    input logic              out_wr_n,
    input logic [BANK_W-1:0] pinned_bank
);
    logic [6:0] sels;
    assign sels = {sel_bank_reg, sel_host_io, sel_zp_shadow, sel_card_rom,
                   sel_bank_win, sel_priv_ram, sel_host_ram};

    a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sels));

    a_r10_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !z_grant |-> (sels == '0 && map_addr == '0 && bank_page == '0 && out_rd_n && out_wr_n));

    a_r9_intack_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!z_iorq_n && !z_m1_n) |-> sels == '0);

    a_r11_refresh_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (z_rd_n && z_wr_n) |-> sels == '0);

    a_r2_page_not_io: assert property (@(posedge clk) disable iff (!rst_n)
        (!z_mreq_n && z_iorq_n && z_addr[15:8] == 8'h9F) |-> !sel_host_io);

    a_r6_vector_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!z_mreq_n && z_addr[15:1] == '0) |-> !sel_host_ram);

    a_r4_card_offset: assert property (@(posedge clk) disable iff (!rst_n)
        sel_card_rom |-> (z_addr[15:14] == 2'b11 && map_addr[15:14] == 2'b00));

    a_r8_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        z_grant |=> $stable(pinned_bank));

    a_r12_strobe_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (sels != '0) |-> (out_rd_n == z_rd_n && out_wr_n == z_wr_n));
endmodule

bind z80_remap_top z80_remap_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .z_addr        (z_addr),
    .z_mreq_n      (z_mreq_n),
    .z_iorq_n      (z_iorq_n),
    .z_rd_n        (z_rd_n),
    .z_wr_n        (z_wr_n),
    .z_m1_n        (z_m1_n),
    .z_grant       (z_grant),
    .sel_host_ram  (sel_host_ram),
    .sel_priv_ram  (sel_priv_ram),
    .sel_bank_win  (sel_bank_win),
    .sel_card_rom  (sel_card_rom),
    .sel_zp_shadow (sel_zp_shadow),
    .sel_host_io   (sel_host_io),
    .sel_bank_reg  (sel_bank_reg),
    .map_addr      (map_addr),
    .bank_page     (bank_page),
    .out_rd_n      (out_rd_n),
    .out_wr_n      (out_wr_n),
    .pinned_bank   (pinned_bank)
);

// File: tb/z80_remap_top_test.sv
// Bench for z80_remap_top: a vector table walked by one loop, then directed tests.
module z80_remap_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] z_addr = '0;
    logic        z_mreq_n = 1'b1, z_iorq_n = 1'b1, z_rd_n = 1'b1, z_wr_n = 1'b1, z_m1_n = 1'b1;
    logic        z_grant = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic        sel_host_ram, sel_priv_ram, sel_bank_win, sel_card_rom;
    logic        sel_zp_shadow, sel_host_io, sel_bank_reg;
    logic [15:0] map_addr;
    logic [7:0]  bank_page;
    logic        out_rd_n, out_wr_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    z80_remap_top uut (.*);

    // Select order: {bank_reg, host_io, zp_shadow, card_rom, bank_win, priv_ram, host_ram}
    // Control order: {mreq_n, iorq_n, rd_n, wr_n, m1_n}
    localparam int NV = 17;
    localparam logic [43:0] VEC [NV] = '{
        {16'h0000, 5'b01011, 7'b0010000, 16'h0000}, // R6 read shadow
        {16'h0001, 5'b01101, 7'b0010000, 16'h0001}, // R6 write shadow
        {16'h0002, 5'b01011, 7'b0000001, 16'h0002}, // R1 low end of host RAM
        {16'h9EFF, 5'b01010, 7'b0000001, 16'h9EFF}, // R1 opcode fetch, top of host RAM
        {16'h9F00, 5'b01101, 7'b0000010, 16'h0000}, // R2 private RAM base
        {16'h9FFF, 5'b01011, 7'b0000010, 16'h00FF}, // R2 private RAM top
        {16'hA000, 5'b01011, 7'b0000100, 16'hA000}, // R3 window base
        {16'hBFFF, 5'b01101, 7'b0000100, 16'hBFFF}, // R3 window top
        {16'hC000, 5'b01011, 7'b0001000, 16'h0000}, // R4 card RAM base
        {16'hFFFF, 5'b01101, 7'b0001000, 16'h3FFF}, // R4 card RAM top
        {16'h1200, 5'b10011, 7'b0100000, 16'h9F00}, // R5 port 00, upper byte ignored
        {16'h34FD, 5'b10101, 7'b0100000, 16'h9FFD}, // R5 port FD
        {16'h00FE, 5'b10011, 7'b1000000, 16'h0000}, // R7 port FE
        {16'hABFF, 5'b10101, 7'b1000000, 16'h0001}, // R7 port FF
        {16'h0038, 5'b10110, 7'b0000000, 16'h0000}, // R9 interrupt acknowledge
        {16'h9F10, 5'b01111, 7'b0000000, 16'h0000}, // R11 refresh
        {16'h5555, 5'b11111, 7'b0000000, 16'h0000}  // R11 idle bus
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] sels();
        return {sel_bank_reg, sel_host_io, sel_zp_shadow, sel_card_rom,
                sel_bank_win, sel_priv_ram, sel_host_ram};
    endfunction

    task automatic drive(input logic [15:0] a, input logic [4:0] c);
        @(negedge clk);
        z_addr = a;
        {z_mreq_n, z_iorq_n, z_rd_n, z_wr_n, z_m1_n} = c;
        #1;
    endtask

    task automatic load_bank(input logic [7:0] v);
        @(negedge clk);
        cfg_data = v;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8 reset value: pinned page is 0 on a window read
        drive(16'hA123, 5'b01011);
        chk(bank_page == 8'h00, "R8 reset page", 32'(bank_page), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            v = VEC[i];
            drive(v[43:28], v[27:23]);
            chk(sels() == v[22:16], $sformatf("table vec %0d select", i), 32'(sels()), 32'(v[22:16]));
            chk(map_addr == v[15:0], $sformatf("table vec %0d address", i), 32'(map_addr), 32'(v[15:0]));
            // R12 strobes follow only while selected
            chk(out_rd_n == ((v[22:16] != 0) ? v[25] : 1'b1) && out_wr_n == ((v[22:16] != 0) ? v[24] : 1'b1),
                $sformatf("R12 strobes vec %0d", i), 32'({out_rd_n, out_wr_n}), 32'(v[25:24]));
        end

        // R8 load while host owns the bus, then R3 page seen by the window
        drive(16'h5555, 5'b11111);
        z_grant = 1'b0;
        load_bank(8'h5A);
        @(negedge clk) z_grant = 1'b1;
        drive(16'hB010, 5'b01011);
        chk(bank_page == 8'h5A, "R3 pinned page", 32'(bank_page), 32'h5A);
        drive(16'h8000, 5'b01011);
        chk(bank_page == 8'h00, "R3 page zero outside window", 32'(bank_page), 32'h0);

        // R8 a load during the grant is ignored
        load_bank(8'h11);
        drive(16'hA000, 5'b01101);
        chk(bank_page == 8'h5A, "R8 write under grant ignored", 32'(bank_page), 32'h5A);

        // R10 grant removed during an active cycle
        drive(16'hC100, 5'b01011);
        z_grant = 1'b0;
        #1;
        chk(sels() == 7'b0, "R10 selects idle", 32'(sels()), 32'h0);
        chk(map_addr == 16'h0 && bank_page == 8'h0, "R10 address idle", 32'(map_addr), 32'h0);
        chk(out_rd_n && out_wr_n, "R10 strobes idle", 32'({out_rd_n, out_wr_n}), 32'h3);
        drive(16'hA000, 5'b01011);
        chk(bank_page == 8'h00, "R10 no page without grant", 32'(bank_page), 32'h0);

        // R8 reset returns the page to 0
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        z_grant = 1'b1;
        drive(16'hA000, 5'b01011);
        chk(bank_page == 8'h00, "R8 page after reset", 32'(bank_page), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule